// File: doc/BRIEF.md
# Hint Encoding Classifier

This block looks at one 32-bit base-integer instruction word and decides whether it is a microarchitectural hint for a 64-bit integer core. A hint is a computational instruction whose architectural effect vanishes, usually because its destination is register zero. When the word is a hint, the block also says which half of the hint space it belongs to. One half is held back for future standard hints. The other half is set aside for implementation-specific hints, and no standard hint will ever be placed there.

Two more cases are reported separately. A word-sized immediate shift whose shift-amount bit 5 is set is a reserved encoding and not a hint. An immediate shift whose upper six bits match no defined shift form is malformed. A core pipeline or a trace monitor feeds words in with a valid strobe. The verdict comes back one clock later, and the core can use it to retire hints as no-ops.

Top module: `hint_classifier`

## Requirements
- R1: After a synchronous active-high reset, all outputs are 0. `out_vld` repeats `in_vld` one clock later. All class flags sampled together with `out_vld` = 0 are 0.
- R2: At most one of `std_o`, `cust_o`, `rsvd_o` and `bad_o` is 1 at a time, and `hint_o` equals `std_o | cust_o`.
- R3: With rd (bits 11:7) equal to 0, opcode 0110111 (load upper) and opcode 0010111 (add upper to pc) give `std_o`.
- R4: Opcode 0010011 with funct3 (bits 14:12) = 000 and rd = 0 gives `std_o` only when rs1 (bits 19:15) or imm (bits 31:20) is nonzero. The all-zero word 0x00000013, the canonical no-op, gives no flag.
- R5: With rd = 0, the following give `std_o`:
  - opcode 0010011 with funct3 100, 110 or 111;
  - opcode 0011011 with funct3 000;
  - opcode 0110011 with funct7 (bits 31:25) = 0000000 and funct3 000, 001, 100, 101, 110 or 111;
  - opcode 0110011 with funct7 = 0100000 and funct3 000 or 101;
  - opcode 0111011 with funct7 = 0000000 and funct3 000, 001 or 101;
  - opcode 0111011 with funct7 = 0100000 and funct3 000 or 101.
- R6: Opcode 0001111 with funct3 000 gives `std_o`, whatever rd is, when bits 27:24 or bits 23:20 are all zero.
- R7: With rd = 0, the following give `cust_o`:
  - opcode 0010011 with funct3 010 or 011;
  - opcode 0110011 with funct7 = 0000000 and funct3 010 or 011.
- R8: Opcode 0010011 immediate shifts with rd = 0 give `cust_o` when:
  - funct3 is 001 and bits 31:26 are 000000; or
  - funct3 is 101 and bits 31:26 are 000000 or 010000.
  Any other value of bits 31:26 for these funct3 values gives `bad_o`, whatever rd is.
- R9: Opcode 0011011 shifts (funct3 001 with bits 31:26 = 000000, or funct3 101 with bits 31:26 = 000000 or 010000) behave as follows:
  - bit 25 = 1 gives `rsvd_o`, whatever rd is;
  - bit 25 = 0 and rd = 0 gives `cust_o`;
  - any other bits 31:26 give `bad_o`.
- R10: A word that matches none of the cases above gives no flag. This covers rd ≠ 0 and unlisted funct7 values such as 0000001 on opcode 0110011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| out_vld | output | 1 | Verdict valid (in_vld delayed one clock) |
| hint_o | output | 1 | Word is a hint of either kind |
| std_o | output | 1 | Hint in the standard-reserved space |
| cust_o | output | 1 | Hint in the custom-reserved space |
| rsvd_o | output | 1 | Reserved word-shift encoding |
| bad_o | output | 1 | Immediate shift with an undefined upper field |

## Verification
The only state is one registered class code and a valid bit, so a fault there appears at the ports in the very next cycle. A corrupted code would show two flags at once or a `hint_o` that does not match the split flags. A stale code would show flags while `out_vld` is low. A decode fault stays invisible until a word hits the faulty pattern, so the stimulus walks every listed funct3/funct7 pair with rd both zero and nonzero, the zero and nonzero fence sets, and the edge of the shift fields. It then adds biased random words, each compared against a behavioural model on every verdict.

// File: rtl/hint_pkg.sv
package hint_pkg;
  localparam int ILEN = 32;
  localparam int OPW  = 7;

  localparam logic [OPW-1:0] OPC_LUI   = 7'b0110111;
  localparam logic [OPW-1:0] OPC_AUIPC = 7'b0010111;
  localparam logic [OPW-1:0] OPC_IMM   = 7'b0010011;
  localparam logic [OPW-1:0] OPC_IMM32 = 7'b0011011;
  localparam logic [OPW-1:0] OPC_REG   = 7'b0110011;
  localparam logic [OPW-1:0] OPC_REG32 = 7'b0111011;
  localparam logic [OPW-1:0] OPC_MEM   = 7'b0001111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [5:0] F6_BASE = 6'b000000;
  localparam logic [5:0] F6_ALT  = 6'b010000;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_STD  = 3'd1,
    CLS_CUST = 3'd2,
    CLS_RSVD = 3'd3,
    CLS_BAD  = 3'd4
  } hint_cls_e;
endpackage

// File: rtl/hint_std_match.sv
module hint_std_match
  import hint_pkg::*;
(
  input  logic [ILEN-1:0] insn_i,
  output logic            std_o
);
  logic [OPW-1:0] opc;
  logic [2:0]     f3;
  logic [6:0]     f7;
  logic           rd0;
  logic           addi_live;
  logic           fence_empty;

  assign opc         = insn_i[6:0];
  assign f3          = insn_i[14:12];
  assign f7          = insn_i[31:25];
  assign rd0         = (insn_i[11:7] == 5'd0);
  assign addi_live   = (insn_i[19:15] != 5'd0) || (insn_i[31:20] != 12'd0);
  assign fence_empty = (insn_i[27:24] == 4'd0) || (insn_i[23:20] == 4'd0);

  always_comb begin
    std_o = 1'b0;
    unique case (opc)
      OPC_LUI, OPC_AUIPC: std_o = rd0;
      OPC_IMM: begin
        case (f3)
          3'b000:                 std_o = rd0 && addi_live;
          3'b100, 3'b110, 3'b111: std_o = rd0;
          default:                std_o = 1'b0;
        endcase
      end
      OPC_IMM32: std_o = rd0 && (f3 == 3'b000);
      OPC_REG: begin
        if (f7 == F7_BASE)
          std_o = rd0 && (f3 != 3'b010) && (f3 != 3'b011);
        else if (f7 == F7_ALT)
          std_o = rd0 && ((f3 == 3'b000) || (f3 == 3'b101));
      end
      OPC_REG32: begin
        if (f7 == F7_BASE)
          std_o = rd0 && ((f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b101));
        else if (f7 == F7_ALT)
          std_o = rd0 && ((f3 == 3'b000) || (f3 == 3'b101));
      end
      OPC_MEM: std_o = (f3 == 3'b000) && fence_empty;
      default: std_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hint_cust_match.sv
module hint_cust_match
  import hint_pkg::*;
(
  input  logic [OPW-1:0] opc_i,
  input  logic [2:0]     f3_i,
  input  logic [6:0]     f7_i,
  input  logic           rd0_i,
  output logic           cust_o,
  output logic           rsvd_o,
  output logic           bad_o
);
  logic [5:0] f6;
  logic       b25;
  logic       left_ok;
  logic       right_ok;

  assign f6       = f7_i[6:1];
  assign b25      = f7_i[0];
  assign left_ok  = (f6 == F6_BASE);
  assign right_ok = (f6 == F6_BASE) || (f6 == F6_ALT);

  always_comb begin
    cust_o = 1'b0;
    rsvd_o = 1'b0;
    bad_o  = 1'b0;
    unique case (opc_i)
      OPC_IMM: begin
        case (f3_i)
          3'b010, 3'b011: cust_o = rd0_i;
          3'b001: begin
            cust_o = rd0_i && left_ok;
            bad_o  = !left_ok;
          end
          3'b101: begin
            cust_o = rd0_i && right_ok;
            bad_o  = !right_ok;
          end
          default: ;
        endcase
      end
      OPC_IMM32: begin
        case (f3_i)
          3'b001: begin
            rsvd_o = left_ok && b25;
            cust_o = left_ok && !b25 && rd0_i;
            bad_o  = !left_ok;
          end
          3'b101: begin
            rsvd_o = right_ok && b25;
            cust_o = right_ok && !b25 && rd0_i;
            bad_o  = !right_ok;
          end
          default: ;
        endcase
      end
      OPC_REG: cust_o = rd0_i && (f7_i == F7_BASE) &&
                        ((f3_i == 3'b010) || (f3_i == 3'b011));
      default: ;
    endcase
  end
endmodule

// File: rtl/hint_classifier.sv
module hint_classifier
  import hint_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [ILEN-1:0] insn_i,
  output logic            out_vld,
  output logic            hint_o,
  output logic            std_o,
  output logic            cust_o,
  output logic            rsvd_o,
  output logic            bad_o
);
  logic      std_hit, cust_hit, rsvd_hit, bad_hit;
  hint_cls_e cls_d, cls_q;
  logic      vld_q;

  hint_std_match u_std (
    .insn_i (insn_i),
    .std_o  (std_hit)
  );

  hint_cust_match u_cust (
    .opc_i  (insn_i[6:0]),
    .f3_i   (insn_i[14:12]),
    .f7_i   (insn_i[31:25]),
    .rd0_i  (insn_i[11:7] == 5'd0),
    .cust_o (cust_hit),
    .rsvd_o (rsvd_hit),
    .bad_o  (bad_hit)
  );

  always_comb begin
    if (bad_hit)       cls_d = CLS_BAD;
    else if (rsvd_hit) cls_d = CLS_RSVD;
    else if (cust_hit) cls_d = CLS_CUST;
    else if (std_hit)  cls_d = CLS_STD;
    else               cls_d = CLS_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cls_q <= CLS_NONE;
    end else begin
      vld_q <= in_vld;
      cls_q <= in_vld ? cls_d : CLS_NONE;
    end
  end

  assign out_vld = vld_q;
  assign std_o   = (cls_q == CLS_STD);
  assign cust_o  = (cls_q == CLS_CUST);
  assign rsvd_o  = (cls_q == CLS_RSVD);
  assign bad_o   = (cls_q == CLS_BAD);
  assign hint_o  = (cls_q == CLS_STD) || (cls_q == CLS_CUST);
endmodule

// File: rtl/hint_classifier_chk.sv
module hint_classifier_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic [31:0] insn_i,
  input logic        out_vld,
  input logic        hint_o,
  input logic        std_o,
  input logic        cust_o,
  input logic        rsvd_o,
  input logic        bad_o
);
  // R2
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({std_o, cust_o, rsvd_o, bad_o}));

  // R2
  hint_split_chk: assert property (@(posedge clk) disable iff (rst)
    hint_o == (std_o | cust_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && !hint_o && !rsvd_o && !bad_o));

  // R3
  upper_x0_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && insn_i[6:0] == 7'b0110111 && insn_i[11:7] == 5'd0) |=> std_o);

  // R4
  canon_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && insn_i == 32'h0000_0013) |=> (out_vld && !hint_o));

  // R8
  bad_slli_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && insn_i[6:0] == 7'b0010011 && insn_i[14:12] == 3'b001 &&
     insn_i[31:26] != 6'd0) |=> bad_o);
endmodule

bind hint_classifier hint_classifier_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .insn_i  (insn_i),
  .out_vld (out_vld),
  .hint_o  (hint_o),
  .std_o   (std_o),
  .cust_o  (cust_o),
  .rsvd_o  (rsvd_o),
  .bad_o   (bad_o)
);

// File: tb/hint_classifier_tb.sv
`timescale 1ns/1ps
module hint_classifier_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] insn_i = 32'd0;
  logic        out_vld, hint_o, std_o, cust_o, rsvd_o, bad_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hint_classifier u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .insn_i(insn_i),
    .out_vld(out_vld), .hint_o(hint_o), .std_o(std_o),
    .cust_o(cust_o), .rsvd_o(rsvd_o), .bad_o(bad_o)
  );

  // classes: 0 none, 1 standard, 2 custom, 3 reserved, 4 malformed
  function automatic int model(input logic [31:0] w);
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    bit z = (w[11:7] == 0);
    bit shl, shr;
    shl = (w[31:26] == 6'b000000);
    shr = shl || (w[31:26] == 6'b010000);
    if (op == 7'h37 || op == 7'h17) return z ? 1 : 0;
    if (op == 7'h0F) return (f3 == 0 && (w[27:24] == 0 || w[23:20] == 0)) ? 1 : 0;
    if (op == 7'h13) begin
      if (f3 == 3'd1) return !shl ? 4 : (z ? 2 : 0);
      if (f3 == 3'd5) return !shr ? 4 : (z ? 2 : 0);
      if (!z) return 0;
      if (f3 == 3'd2 || f3 == 3'd3) return 2;
      if (f3 == 3'd0) return (w[31:15] != 0) ? 1 : 0;
      return 1;
    end
    if (op == 7'h1B) begin
      if (f3 == 3'd1 || f3 == 3'd5) begin
        if ((f3 == 3'd1) ? !shl : !shr) return 4;
        if (w[25]) return 3;
        return z ? 2 : 0;
      end
      return (z && f3 == 0) ? 1 : 0;
    end
    if (!z) return 0;
    if (op == 7'h33) begin
      if (f7 == 7'h00) return (f3 == 2 || f3 == 3) ? 2 : 1;
      if (f7 == 7'h20) return (f3 == 0 || f3 == 5) ? 1 : 0;
      return 0;
    end
    if (op == 7'h3B) begin
      if (f7 == 7'h00) return (f3 == 0 || f3 == 1 || f3 == 5) ? 1 : 0;
      if (f7 == 7'h20) return (f3 == 0 || f3 == 5) ? 1 : 0;
    end
    return 0;
  endfunction

  function automatic logic [5:0] expect_bits(input bit v, input int c);
    // {out_vld, hint, std, cust, rsvd, bad}
    if (!v) return 6'b000000;
    case (c)
      1: return 6'b111000;
      2: return 6'b110100;
      3: return 6'b100010;
      4: return 6'b100001;
      default: return 6'b100000;
    endcase
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  task automatic apply(input string tag, input bit v, input logic [31:0] w);
    logic [5:0] exp, got;
    @(negedge clk);
    in_vld = v;
    insn_i = w;
    exp = expect_bits(v, model(w));
    @(posedge clk);
    #1;
    got = {out_vld, hint_o, std_o, cust_o, rsvd_o, bad_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s insn=%h got=%b expected=%b", tag, w, got, exp);
    end
    checks++;
    if ((hint_o !== (std_o | cust_o)) || ($countones({std_o, cust_o, rsvd_o, bad_o}) > 1)) begin
      fails++;
      $display("FAIL R2 insn=%h got=%b expected=exclusive flags", w, got);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({out_vld, hint_o, std_o, cust_o, rsvd_o, bad_o} !== 6'b0) begin
      fails++;
      $display("FAIL R1 reset got=%b expected=000000",
               {out_vld, hint_o, std_o, cust_o, rsvd_o, bad_o});
    end
    @(negedge clk);
    rst = 1'b0;

    apply("R1 idle", 1'b0, {20'hABCDE, 5'd0, 7'h37});
    apply("R3 lui x0", 1'b1, {20'hABCDE, 5'd0, 7'h37});
    apply("R3 auipc x0", 1'b1, {20'h00001, 5'd0, 7'h17});
    apply("R10 lui x5", 1'b1, {20'hABCDE, 5'd5, 7'h37});
    apply("R4 nop", 1'b1, 32'h0000_0013);
    apply("R4 addi rs1", 1'b1, enc_i(12'd0, 5'd1, 3'd0, 5'd0, 7'h13));
    apply("R4 addi imm", 1'b1, enc_i(12'd1, 5'd0, 3'd0, 5'd0, 7'h13));
    apply("R10 addi x3", 1'b1, enc_i(12'd0, 5'd1, 3'd0, 5'd3, 7'h13));
    apply("R5 andi", 1'b1, enc_i(12'h0F0, 5'd2, 3'd7, 5'd0, 7'h13));
    apply("R5 ori", 1'b1, enc_i(12'h0F0, 5'd2, 3'd6, 5'd0, 7'h13));
    apply("R5 xori", 1'b1, enc_i(12'h0F0, 5'd2, 3'd4, 5'd0, 7'h13));
    apply("R5 addiw", 1'b1, enc_i(12'h7FF, 5'd2, 3'd0, 5'd0, 7'h1B));
    apply("R5 add", 1'b1, enc_r(7'h00, 5'd3, 5'd2, 3'd0, 5'd0, 7'h33));
    apply("R5 sub", 1'b1, enc_r(7'h20, 5'd3, 5'd2, 3'd0, 5'd0, 7'h33));
    apply("R5 sra", 1'b1, enc_r(7'h20, 5'd3, 5'd2, 3'd5, 5'd0, 7'h33));
    apply("R5 subw", 1'b1, enc_r(7'h20, 5'd3, 5'd2, 3'd0, 5'd0, 7'h3B));
    apply("R5 sraw", 1'b1, enc_r(7'h20, 5'd3, 5'd2, 3'd5, 5'd0, 7'h3B));
    apply("R5 sllw", 1'b1, enc_r(7'h00, 5'd3, 5'd2, 3'd1, 5'd0, 7'h3B));
    apply("R10 mul x0", 1'b1, enc_r(7'h01, 5'd3, 5'd2, 3'd0, 5'd0, 7'h33));
    apply("R6 fence pred0", 1'b1, 32'h00F0_000F);
    apply("R6 fence succ0", 1'b1, 32'h0F00_028F);
    apply("R6 fence full", 1'b1, 32'h0FF0_000F);
    apply("R7 slti", 1'b1, enc_i(12'h005, 5'd2, 3'd2, 5'd0, 7'h13));
    apply("R7 sltiu", 1'b1, enc_i(12'h005, 5'd2, 3'd3, 5'd0, 7'h13));
    apply("R7 slt", 1'b1, enc_r(7'h00, 5'd3, 5'd2, 3'd2, 5'd0, 7'h33));
    apply("R7 sltu", 1'b1, enc_r(7'h00, 5'd3, 5'd2, 3'd3, 5'd0, 7'h33));
    apply("R10 slt x5", 1'b1, enc_r(7'h00, 5'd3, 5'd2, 3'd2, 5'd5, 7'h33));
    apply("R8 slli 33", 1'b1, enc_i(12'h021, 5'd2, 3'd1, 5'd0, 7'h13));
    apply("R8 srai 63", 1'b1, enc_i(12'h43F, 5'd2, 3'd5, 5'd0, 7'h13));
    apply("R8 slli alt", 1'b1, enc_i(12'h401, 5'd2, 3'd1, 5'd0, 7'h13));
    apply("R8 srli f6 bad x5", 1'b1, enc_i(12'h041, 5'd2, 3'd5, 5'd5, 7'h13));
    apply("R9 slliw", 1'b1, enc_r(7'h00, 5'd4, 5'd2, 3'd1, 5'd0, 7'h1B));
    apply("R9 sraiw", 1'b1, enc_r(7'h20, 5'd4, 5'd2, 3'd5, 5'd0, 7'h1B));
    apply("R9 slliw b25", 1'b1, enc_r(7'h01, 5'd4, 5'd2, 3'd1, 5'd0, 7'h1B));
    apply("R9 srliw b25 x3", 1'b1, enc_r(7'h01, 5'd4, 5'd2, 3'd5, 5'd3, 7'h1B));
    apply("R9 sraiw f6 bad", 1'b1, enc_r(7'h60, 5'd4, 5'd2, 3'd5, 5'd0, 7'h1B));
    apply("R10 srliw x3", 1'b1, enc_r(7'h00, 5'd4, 5'd2, 3'd5, 5'd3, 7'h1B));

    for (int i = 0; i < 800; i++) begin
      logic [31:0] w;
      logic [6:0] ops [7];
      ops = '{7'h37, 7'h17, 7'h13, 7'h1B, 7'h33, 7'h3B, 7'h0F};
      w = $urandom;
      w[6:0] = ops[$urandom_range(0, 6)];
      if ($urandom_range(0, 1) == 1) w[11:7] = 5'd0;
      case ($urandom_range(0, 3))
        0: w[31:25] = 7'h00;
        1: w[31:25] = 7'h20;
        2: w[31:26] = 6'h00;
        default: ;
      endcase
      if ($urandom_range(0, 3) == 0) w[23:20] = 4'd0;
      apply("R10 random", ($urandom_range(0, 7) != 0), w);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule